// File: doc/BRIEF.md
# E3 Frame Alignment Maintenance

This block watches a recovered E3 bit stream, one bit per clock, and keeps track of where each frame starts. It hunts bit by bit for the 10-bit alignment word, confirms it one frame later at the same offset, and then checks it once per frame. Scattered corruption of the alignment word is tolerated and counted. Only a run of bad words causes the block to give up alignment and raise an out-of-frame flag. A loss-of-frame flag follows if the out-of-frame condition lasts long enough.

A host reaches the block through a small register port with four byte addresses: a control byte whose bit 0 forces a new hunt, a status byte, and two bytes of a clear-on-read error counter. Reading the low byte freezes the high byte, so the host can assemble a consistent 16-bit value from the two reads.

Top module: `e3_frame_align`

## Requirements
- R1: On the clock edge that accepts the confirming alignment word, `oof_o` and `lof_o` both go low together, and the status byte bits follow. `lof_o` never falls while `oof_o` stays high.
- R2: The alignment word is 1111010000, with the leftmost bit received first. While hunting, the block slides one bit at a time. A match moves it to confirmation. It reaches in-frame only if the word appears again exactly FRAME_BITS bits later. If it does not, the block returns to hunting and needs two further correctly spaced words.
- R3: While in frame, `oof_o` rises on the edge that evaluates the fourth consecutive bad alignment word. One to three bad words followed by a good one leave `oof_o` low.
- R4: Each in-frame frame with a bad alignment word adds one to the error counter, including the frame that declares out-of-frame.
- R5: The error counter stops at 2^CNT_W-1 and does not wrap.
- R6: Reading address 3 returns bits 7:0 of the counter. The same read captures bits 15:8 for address 2 and clears the counter. An error counted in the same cycle leaves the counter at 1.
- R7: A write to address 0 with data bit 0 set sends the block to hunting and raises `oof_o` on the next edge, whatever the state. A write with bit 0 clear has no effect.
- R8: `lof_o` rises LOF_FRAMES*FRAME_BITS clock edges after `oof_o` rises, if `oof_o` stays high that long. `lof_o` is never high while `oof_o` is low.
- R9: Reading address 1 returns loss-of-frame in bit 6 and out-of-frame in bit 5. All other bits read 0.
- R10: After reset, `oof_o`, `lof_o`, the status byte and both counter bytes read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial receive data, one bit per clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects on address 3) |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 count high, 3 count low |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| oof_o | output | 1 | Out-of-frame flag |
| lof_o | output | 1 | Loss-of-frame flag |

## Verification
The situation hardest to reach from the ports is a saturated error counter. It needs hundreds of bad words while the block stays in frame, so no run of bad words may reach four. The stimulus holds a repeating pattern of one good word followed by three corrupted ones for several hundred frames, then reads both bytes. The loss-of-frame window is reached in a similar way. Unmatchable all-ones words are fed during the hunt, and the payload has a 1 forced at every fourth bit, so no false alignment can end the out-of-frame period early.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;
  localparam int          FAS_W    = 10;
  localparam logic [9:0]  FAS_WORD = 10'b1111010000;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STAT   = 2'd1;
  localparam logic [1:0] ADDR_CNT_HI = 2'd2;
  localparam logic [1:0] ADDR_CNT_LO = 2'd3;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } align_state_e;
endpackage

// File: rtl/e3fa_fas_match.sv
module e3fa_fas_match
  import e3fa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic hit_o
);
  logic [FAS_W-2:0] hist_q;

  // hit reflects the window that ends with the bit presented this cycle
  assign hit_o = ({hist_q, bit_i} == FAS_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[FAS_W-3:0], bit_i};
  end
endmodule

// File: rtl/e3fa_align_fsm.sv
module e3fa_align_fsm
  import e3fa_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int BAD_LIMIT  = 4,
  parameter int LOF_FRAMES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic reframe_i,
  output logic oof_o,
  output logic lof_o,
  output logic fas_err_o
);
  localparam int POS_W     = $clog2(FRAME_BITS);
  localparam int BAD_W     = $clog2(BAD_LIMIT + 1);
  localparam int LOF_LIMIT = LOF_FRAMES * FRAME_BITS;
  localparam int LOF_W     = $clog2(LOF_LIMIT + 1);

  align_state_e     state_q;
  logic [POS_W-1:0] pos_q;
  logic [BAD_W-1:0] bad_q;
  logic [LOF_W-1:0] tmr_q;
  logic             frame_end;

  assign frame_end = (pos_q == POS_W'(FRAME_BITS - 1));
  assign fas_err_o = (state_q == ST_LOCKED) && frame_end && !hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      bad_q   <= '0;
      tmr_q   <= '0;
      oof_o   <= 1'b0;
      lof_o   <= 1'b0;
    end else begin
      // loss-of-frame timer runs only while out of frame
      if (!oof_o) tmr_q <= '0;
      else if (!lof_o) begin
        if (tmr_q == LOF_W'(LOF_LIMIT - 1)) lof_o <= 1'b1;
        else                                tmr_q <= tmr_q + 1'b1;
      end

      pos_q <= frame_end ? '0 : pos_q + 1'b1;

      if (reframe_i) begin
        state_q <= ST_HUNT;
        bad_q   <= '0;
        oof_o   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_HUNT: if (hit_i) begin
            state_q <= ST_CONFIRM;
            pos_q   <= '0;
          end
          ST_CONFIRM: if (frame_end) begin
            if (hit_i) begin
              state_q <= ST_LOCKED;
              bad_q   <= '0;
              oof_o   <= 1'b0;
              lof_o   <= 1'b0;
            end else begin
              state_q <= ST_HUNT;
            end
          end
          ST_LOCKED: if (frame_end) begin
            if (hit_i) bad_q <= '0;
            else if (bad_q == BAD_W'(BAD_LIMIT - 1)) begin
              state_q <= ST_HUNT;
              bad_q   <= '0;
              oof_o   <= 1'b1;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/e3fa_err_cnt.sv
module e3fa_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        inc_i,
  input  logic        rd_lo_i,
  output logic [15:0] cnt_o,
  output logic [7:0]  hi_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hi_q;

  assign cnt_o = 16'(cnt_q);
  assign hi_o  = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else if (rd_lo_i) begin
      hi_q  <= cnt_o[15:8];
      cnt_q <= inc_i ? CNT_W'(1) : '0;
    end else if (inc_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/e3_frame_align.sv
module e3_frame_align
  import e3fa_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int BAD_LIMIT  = 4,
  parameter int LOF_FRAMES = 8,
  parameter int CNT_W      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_bit_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       oof_o,
  output logic       lof_o
);
  logic        hit;
  logic        reframe;
  logic        err_inc;
  logic        rd_lo;
  logic [15:0] err_cnt;
  logic [7:0]  err_hi;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata_i[7:1];
  assign reframe = reg_we_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[0];
  assign rd_lo   = reg_re_i && (reg_addr_i == ADDR_CNT_LO);

  e3fa_fas_match u_match (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (rx_bit_i),
    .hit_o (hit)
  );

  e3fa_align_fsm #(
    .FRAME_BITS(FRAME_BITS),
    .BAD_LIMIT (BAD_LIMIT),
    .LOF_FRAMES(LOF_FRAMES)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .reframe_i(reframe),
    .oof_o    (oof_o),
    .lof_o    (lof_o),
    .fas_err_o(err_inc)
  );

  e3fa_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (err_inc),
    .rd_lo_i(rd_lo),
    .cnt_o  (err_cnt),
    .hi_o   (err_hi)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_STAT:   reg_rdata_o = {1'b0, lof_o, oof_o, 5'b0};
      ADDR_CNT_HI: reg_rdata_o = err_hi;
      ADDR_CNT_LO: reg_rdata_o = err_cnt[7:0];
      default:     reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/e3fa_checker.sv
module e3fa_checker #(
  parameter int CNT_W = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        oof_i,
  input logic        lof_i,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic        reg_wdata0_i,
  input logic [7:0]  reg_rdata_i,
  input logic        err_inc_i,
  input logic        rd_lo_i,
  input logic [15:0] cnt_i
);
  localparam logic [15:0] CNT_MAX = 16'((1 << CNT_W) - 1);

  assert_lof_needs_oof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lof_i |-> oof_i);

  assert_flags_clear_together_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_i) |-> $fell(oof_i));

  assert_reframe_sets_oof_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata0_i) |=> oof_i);

  assert_status_layout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd1) |-> (reg_rdata_i == {1'b0, lof_i, oof_i, 5'b0}));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !rd_lo_i) |=> (cnt_i == CNT_MAX));

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !err_inc_i) |=> (cnt_i == 16'd0));

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_inc_i && !rd_lo_i && cnt_i != CNT_MAX) |=> (cnt_i == $past(cnt_i) + 16'd1));
endmodule

bind e3_frame_align e3fa_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .oof_i       (oof_o),
  .lof_i       (lof_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata0_i(reg_wdata_i[0]),
  .reg_rdata_i (reg_rdata_o),
  .err_inc_i   (err_inc),
  .rd_lo_i     (rd_lo),
  .cnt_i       (err_cnt)
);

// File: tb/sim_e3_frame_align.sv
module sim_e3_frame_align;
  localparam int CLK_PERIOD = 10;
  localparam int FB         = 64;
  localparam int LF         = 3;
  localparam int CW         = 9;
  localparam int CMAX       = (1 << CW) - 1;
  localparam logic [9:0] FAS = 10'b1111010000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       oof, lof;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_state = 0;
  bit m_oof = 0;
  int m_bad = 0;
  int m_cnt = 0;
  int m_age = 0;
  bit m_decl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e3_frame_align #(
    .FRAME_BITS(FB), .BAD_LIMIT(4), .LOF_FRAMES(LF), .CNT_W(CW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .oof_o(oof), .lof_o(lof)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_lof();
    return m_oof && (m_age >= LF);
  endfunction

  function automatic logic [7:0] exp_status();
    return {1'b0, exp_lof(), m_oof, 5'b0};
  endfunction

  task automatic declare_oof();
    if (!m_oof) begin
      m_oof = 1;
      m_age = 0;
      m_decl = 1;
    end
  endtask

  task automatic model_fas(input bit ok);
    case (m_state)
      0: if (ok) m_state = 1;
      1: if (ok) begin m_state = 2; m_oof = 0; m_bad = 0; end
         else m_state = 0;
      default: if (ok) m_bad = 0;
        else begin
          if (m_cnt < CMAX) m_cnt++;
          if (m_bad == 3) begin m_state = 0; m_bad = 0; declare_oof(); end
          else m_bad++;
        end
    endcase
  endtask

  task automatic model_reframe();
    m_state = 0;
    m_bad = 0;
    declare_oof();
  endtask

  task automatic model_age();
    if (m_oof) begin
      if (m_decl) m_decl = 0;
      else if (m_age < 100) m_age++;
    end
  endtask

  function automatic logic fill_bit(input int i);
    return ((i % 4) == 3) ? 1'b1 : 1'($urandom % 2);
  endfunction

  // act: 0 none, 1 reframe, 2 read counter, 3 read status, 4 write ctrl with bit0 clear
  task automatic send_frame(input bit ok, input int act);
    logic [9:0] w;
    logic [7:0] got;
    int exp_cnt;
    if (ok) w = FAS;
    else if (m_state == 2) w = FAS ^ (10'd1 << ($urandom % 10));
    else w = 10'h3FF;
    exp_cnt = 0;
    for (int i = 0; i < FB; i++) begin
      @(negedge clk);
      if (i == 10) model_fas(ok);
      if (i == 31 && act == 1) model_reframe();
      if (i == 40) model_age();
      we = 0; re = 0; addr = 2'd0; wdata = 8'd0;
      rx = (i < 10) ? w[9 - i] : fill_bit(i);
      if (act == 1 && i == 30) begin we = 1; addr = 2'd0; wdata = 8'h01; end
      if (act == 4 && i == 30) begin we = 1; addr = 2'd0; wdata = 8'hFE; end
      if (act == 2 && i == 20) begin
        re = 1; addr = 2'd3; #1; got = rdata;
        exp_cnt = m_cnt;
        check(got == 8'(exp_cnt), "R4/R5/R6 count low byte", got, 8'(exp_cnt));
        m_cnt = 0;
      end
      if (act == 2 && i == 21) begin
        addr = 2'd2; #1; got = rdata;
        check(got == 8'(exp_cnt >> 8), "R6 latched high byte", got, 8'(exp_cnt >> 8));
      end
      if (act == 3 && i == 62) begin
        addr = 2'd1; #1; got = rdata;
        check(got == exp_status(), "R9 status byte", got, exp_status());
      end
    end
    #1;
    check(oof == m_oof, "R1/R2/R3/R7 oof_o", oof, m_oof);
    check(lof == exp_lof(), "R1/R8 lof_o", lof, exp_lof());
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rx = 0; re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 0; addr = 2'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    #1;
    check(oof == 0, "R10 oof after reset", oof, 0);
    check(lof == 0, "R10 lof after reset", lof, 0);
    reg_read(2'd1, d); check(d == 8'h00, "R10 status after reset", d, 0);
    reg_read(2'd3, d); check(d == 8'h00, "R10 count low after reset", d, 0);
    reg_read(2'd2, d); check(d == 8'h00, "R10 count high after reset", d, 0);

    // arbitrary lead-in offset
    for (int i = 0; i < 23; i++) begin
      @(negedge clk);
      rx = fill_bit(i);
    end

    // R2 initial lock
    repeat (3) send_frame(1, 0);

    // R3 three bad words tolerated, R4 counted
    repeat (3) send_frame(0, 0);
    send_frame(1, 0);
    send_frame(1, 2);

    // R7 write with bit0 clear has no effect
    send_frame(1, 4);

    // R3 fourth bad word declares out-of-frame; R8 loss-of-frame follows
    repeat (4) send_frame(0, 3);
    repeat (4) send_frame(0, 3);

    // R1 both flags clear on relock
    send_frame(1, 3);
    send_frame(1, 3);
    send_frame(1, 3);

    // R7 forced reframe; R2 failed confirmation returns to hunting
    send_frame(1, 1);
    send_frame(1, 3);
    send_frame(0, 0);
    send_frame(1, 0);
    send_frame(1, 3);
    send_frame(1, 2);

    // mixed random phase
    for (int n = 0; n < 200; n++) begin
      int r;
      int act;
      r = int'($urandom % 100);
      act = (r < 3) ? 1 : (r < 13) ? 2 : (r < 23) ? 3 : (r < 26) ? 4 : 0;
      send_frame(($urandom % 100) < 70, act);
    end

    // relock and clear counter
    repeat (3) send_frame(1, 0);
    send_frame(1, 2);

    // R5 saturation: 525 errors without leaving frame
    for (int n = 0; n < 700; n++) send_frame((n % 4) == 0, 0);
    send_frame(1, 2);
    send_frame(1, 2);

    // R6 coherent 16-bit read above 255
    for (int n = 0; n < 400; n++) send_frame((n % 4) == 0, 0);
    send_frame(1, 2);
    send_frame(1, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule